// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Unit

This block holds three 32-bit timer channels that count down and a shared start register with one run bit per channel. Each channel picks its count source: one of five fixed divisions of the block clock, rising edges of a real-time-clock tick input, or edges of an external clock pin. For the pin, the channel selects rising, falling or both edges. When a counter steps below zero it reloads from that channel's constant register and raises an underflow flag. The flag can drive the channel's interrupt line.

The last channel can also capture. On the selected edge of the external pin it copies its live counter value into a capture register that software can only read, and it sets a capture flag. Both asynchronous inputs pass through two synchronising flops before edge detection. Software reaches every register through a plain single-cycle register port. A write takes effect at the clock edge on which `reg_wr` is high, and a read is combinational from `reg_addr`. No stream interface exists, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_unit`

## Requirements
- R1: After reset every counter and constant register reads 0xFFFFFFFF. Every control register, the start register and the capture register read 0, and `irq` is 0.
- R2: The start register is at byte offset 0x04, with bit n running channel n. A channel whose bit is 0 holds its counter.
- R3: Channel n has its constant at 0x08+12n, its counter at 0x0C+12n and its control at 0x10+12n. The capture register is at 0x2C, and writes to it are ignored.
- R4: Control bits 2:0 select the source. Codes 0 to 4 decrement once every 4, 16, 64, 256 and 1024 clocks. The dividers are free-running, so a run window of exactly k·N clocks removes exactly k counts.
- R5: Source code 5 never counts. Code 6 decrements once per rising edge of `rtc_clk_i`.
- R6: Source code 7 counts edges of `ext_clk_i` chosen by control bits 4:3. Value 00 counts rising edges, 01 falling edges, and 11 or 10 both edges.
- R7: When a counter steps below zero, it reloads from its constant and sets underflow flag bit 8 in the same cycle.
- R8: In a control write, writing 0 to flag bit 8 or flag bit 9 clears that flag, and writing 1 leaves it unchanged.
- R9: Each `irq[n]` equals (flag bit 8 AND enable bit 5), ORed with (capture flag bit 9 AND capture mode 11) on the capture channel. Enabling after the flag is already set raises the line.
- R10: On channel 2, capture mode bits 7:6 work as follows. Values 10 and 11 copy the counter into the capture register on the selected pin edge and set bit 9, and 00 captures nothing. Channels 0 and 1 read 0 in bits 9:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rtc_clk_i | input | 1 | Asynchronous real-time-clock tick |
| ext_clk_i | input | 1 | Asynchronous external count / capture pin |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The bench opens run windows of exactly k·N clocks for each divider. A design with the wrong tap, or one that restarts its divider phase when the start bit is written, would remove the wrong number of counts. Each edge mode is checked with a rise seen on its own, before the fall arrives. A design that swaps the edge codes, or that ignores code 10, would step at the wrong moment. The underflow checks step through 1, 0 and then the reload. A design that decrements into 0xFFFFFFFF, or that sets the flag a step late, shows a wrong counter or a clear flag. The capture checks cover mode 00 and the falling-edge selection. They also write to the capture register, which would change a capture value that is not read-only.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    PS_D4 = 3'd0, PS_D16 = 3'd1, PS_D64 = 3'd2, PS_D256 = 3'd3,
    PS_D1024 = 3'd4, PS_RSV = 3'd5, PS_RTC = 3'd6, PS_EXT = 3'd7
  } psel_e;

  typedef enum logic [1:0] {
    EDG_RISE = 2'd0, EDG_FALL = 2'd1, EDG_BOTH_ALT = 2'd2, EDG_BOTH = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    CAP_OFF = 2'd0, CAP_NONE = 2'd1, CAP_QUIET = 2'd2, CAP_IRQ = 2'd3
  } capm_e;

  // bit 9 capture flag, 8 underflow flag, 7:6 capture mode,
  // 5 underflow irq enable, 4:3 edge select, 2:0 source select
  typedef struct packed {
    logic  capf;
    logic  unf;
    capm_e capm;
    logic  unie;
    edge_e edg;
    psel_e psel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DIV-1:0] div_tick
);
  localparam int CW = 2 * NUM_DIV;

  logic [CW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 4^(k+1) clocks
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    assign div_tick[k] = &pre_q[2*k+1:0];
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_DIV = 5,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_DIV-1:0] div_tick,
  input  logic               rtc_rise,
  input  logic               ext_rise,
  input  logic               ext_fall,
  input  logic               wr_const,
  input  logic               wr_cnt,
  input  logic               wr_ctrl,
  input  logic [W-1:0]       wdata,
  output logic [W-1:0]       cnt_o,
  output logic [W-1:0]       const_o,
  output logic [W-1:0]       cap_o,
  output ctrl_t              ctrl_o,
  output logic               irq_o
);
  logic [W-1:0] cnt_q, const_q;
  psel_e        psel_q;
  edge_e        edg_q;
  logic         unie_q, unf_q;
  logic         ext_hit, step, unf_set;
  logic         capf_w, cap_irq_w;
  capm_e        capm_w;

  always_comb begin
    unique case (edg_q)
      EDG_RISE: ext_hit = ext_rise;
      EDG_FALL: ext_hit = ext_fall;
      default:  ext_hit = ext_rise | ext_fall;
    endcase
  end

  always_comb begin
    step = 1'b0;
    if (int'(psel_q) < NUM_DIV) step = div_tick[psel_q];
    else if (psel_q == PS_RTC)  step = rtc_rise;
    else if (psel_q == PS_EXT)  step = ext_hit;
  end

  assign unf_set = !wr_cnt && run && step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      const_q <= '1;
      psel_q  <= PS_D4;
      edg_q   <= EDG_RISE;
      unie_q  <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (wr_const) const_q <= wdata;
      if (wr_cnt) cnt_q <= wdata;
      else if (run && step) cnt_q <= (cnt_q == '0) ? const_q : cnt_q - 1'b1;
      if (wr_ctrl) begin
        psel_q <= psel_e'(wdata[2:0]);
        edg_q  <= edge_e'(wdata[4:3]);
        unie_q <= wdata[5];
        unf_q  <= (unf_q & wdata[8]) | unf_set;
      end else begin
        unf_q  <= unf_q | unf_set;
      end
    end
  end

  if (HAS_CAP) begin : g_cap
    logic [W-1:0] cap_q;
    logic         capf_q;
    capm_e        capm_q;
    logic         cap_ev;

    assign cap_ev = ((capm_q == CAP_QUIET) || (capm_q == CAP_IRQ)) && ext_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_q  <= '0;
        capf_q <= 1'b0;
        capm_q <= CAP_OFF;
      end else begin
        if (wr_ctrl) capm_q <= capm_e'(wdata[7:6]);
        if (cap_ev) cap_q <= cnt_q;
        if (wr_ctrl) capf_q <= (capf_q & wdata[9]) | cap_ev;
        else         capf_q <= capf_q | cap_ev;
      end
    end

    assign cap_o     = cap_q;
    assign capf_w    = capf_q;
    assign capm_w    = capm_q;
    assign cap_irq_w = capf_q && (capm_q == CAP_IRQ);
  end else begin : g_nocap
    assign cap_o     = '0;
    assign capf_w    = 1'b0;
    assign capm_w    = CAP_OFF;
    assign cap_irq_w = 1'b0;
  end

  assign cnt_o   = cnt_q;
  assign const_o = const_q;
  assign ctrl_o  = '{capf: capf_w, unf: unf_q, capm: capm_w, unie: unie_q,
                     edg: edg_q, psel: psel_q};
  assign irq_o   = (unf_q && unie_q) || cap_irq_w;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUM_CH    = 3,
  parameter int CAP_CH    = 2,
  parameter int NUM_DIV   = 5,
  parameter int AW        = 8,
  parameter int START_OFS = 4,
  parameter int CH_BASE   = 8,
  parameter int CH_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              rtc_clk_i,
  input  logic              ext_clk_i,
  output logic [NUM_CH-1:0] irq
);
  localparam int CAP_OFS = CH_BASE + NUM_CH * CH_STRIDE;

  logic [NUM_DIV-1:0] div_tick;
  logic               rtc_rise, rtc_fall, ext_rise, ext_fall;
  logic [NUM_CH-1:0]  start_q;
  logic [W-1:0]       cnt_w   [NUM_CH];
  logic [W-1:0]       const_w [NUM_CH];
  logic [W-1:0]       cap_w   [NUM_CH];
  ctrl_t              ctrl_w  [NUM_CH];
  logic [NUM_CH-1:0]  hit_const, hit_cnt, hit_ctrl;
  logic               hit_start, hit_cap;

  tmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick)
  );

  tmr_edge_sync u_rtc_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rtc_clk_i),
    .rise_o(rtc_rise), .fall_o(rtc_fall)
  );

  tmr_edge_sync u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign hit_start = (reg_addr == AW'(START_OFS));
  assign hit_cap   = (reg_addr == AW'(CAP_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n)                  start_q <= '0;
    else if (reg_wr && hit_start) start_q <= reg_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int OFS = CH_BASE + CH_STRIDE * i;
    assign hit_const[i] = (reg_addr == AW'(OFS));
    assign hit_cnt[i]   = (reg_addr == AW'(OFS + 4));
    assign hit_ctrl[i]  = (reg_addr == AW'(OFS + 8));

    tmr_channel #(.W(W), .NUM_DIV(NUM_DIV), .HAS_CAP(i == CAP_CH)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(start_q[i]), .div_tick(div_tick),
      .rtc_rise(rtc_rise), .ext_rise(ext_rise), .ext_fall(ext_fall),
      .wr_const(reg_wr && hit_const[i]), .wr_cnt(reg_wr && hit_cnt[i]),
      .wr_ctrl(reg_wr && hit_ctrl[i]), .wdata(reg_wdata),
      .cnt_o(cnt_w[i]), .const_o(const_w[i]), .cap_o(cap_w[i]),
      .ctrl_o(ctrl_w[i]), .irq_o(irq[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_start) reg_rdata[NUM_CH-1:0] = start_q;
    if (hit_cap)   reg_rdata = cap_w[CAP_CH];
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_const[i]) reg_rdata = const_w[i];
      if (hit_cnt[i])   reg_rdata = cnt_w[i];
      if (hit_ctrl[i])  reg_rdata = W'(ctrl_w[i]);
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUM_CH    = 3,
  parameter int AW        = 8,
  parameter int CTRL0_OFS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [NUM_CH-1:0] start_q,
  input logic [W-1:0]      cnt0,
  input logic [W-1:0]      const0,
  input ctrl_t             ctrl0,
  input logic [W-1:0]      cnt2,
  input logic [W-1:0]      cap2,
  input ctrl_t             ctrl2
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q[0] && !reg_wr) |=> $stable(cnt0)); // R2

  AST_RSV_SOURCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0.psel == PS_RSV && !reg_wr) |=> $stable(cnt0)); // R5

  AST_RELOAD_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl0.unf) |-> (cnt0 == $past(const0))); // R7

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0.unf && !(reg_wr && reg_addr == AW'(CTRL0_OFS) && !reg_wdata[8]))
      |=> ctrl0.unf); // R8

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl2.capf) |-> (cap2 == $past(cnt2))); // R10
endmodule

bind tmr_unit tmr_unit_chk #(
  .W(W), .NUM_CH(NUM_CH), .AW(AW), .CTRL0_OFS(CH_BASE + 8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .start_q(start_q), .cnt0(cnt_w[0]),
  .const0(const_w[0]), .ctrl0(ctrl_w[0]), .cnt2(cnt_w[2]),
  .cap2(cap_w[CAP_CH]), .ctrl2(ctrl_w[2])
);

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rtc_clk_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic [2:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit pend    = 1'b0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t sb[$];
  item_t it;
  logic [31:0] act;

  localparam logic [7:0] A_START = 8'h04, A_CAP = 8'h2C;
  function automatic logic [7:0] a_const(int n); return 8'(8 + 12*n);  endfunction
  function automatic logic [7:0] a_cnt(int n);   return 8'(12 + 12*n); endfunction
  function automatic logic [7:0] a_ctrl(int n);  return 8'(16 + 12*n); endfunction

  always #5 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_clk_i(rtc_clk_i),
    .ext_clk_i(ext_clk_i), .irq(irq)
  );

  // monitor: pops expected items and compares mid low phase
  always @(negedge clk) begin
    #2;
    if (pend && sb.size() > 0) begin
      it  = sb.pop_front();
      act = it.is_irq ? {29'b0, irq} : reg_rdata;
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{exp: e, is_irq: 1'b0, tag: tag});
    pend = 1'b1; #4; pend = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    @(negedge clk);
    sb.push_back('{exp: {29'b0, e}, is_irq: 1'b1, tag: tag});
    pend = 1'b1; #4; pend = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk_i = 1'b1; wait_cyc(6);
    ext_clk_i = 1'b0; wait_cyc(6);
  endtask

  task automatic rtc_pulse();
    @(negedge clk); rtc_clk_i = 1'b1; wait_cyc(6);
    rtc_clk_i = 1'b0; wait_cyc(6);
  endtask

  // run channel 0 for exactly k*n clocks of source code sel
  task automatic div_window(input int sel, input int n, input int k, input string tag);
    wr(a_cnt(0), 32'd100);
    wr(a_ctrl(0), 32'(sel));
    wr(A_START, 32'd1);
    wait_cyc(k*n - 2);
    wr(A_START, 32'd0);
    chk(a_cnt(0), 32'(100 - k), tag);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk(a_cnt(0), 32'hFFFF_FFFF, "R1 cnt0");
    chk(a_const(1), 32'hFFFF_FFFF, "R1 const1");
    chk(a_ctrl(2), 32'h0, "R1 ctrl2");
    chk(A_START, 32'h0, "R1 start");
    chk(A_CAP, 32'h0, "R1 cap");
    chk_irq(3'b000, "R1 irq");

    // R4 fixed dividers
    div_window(0, 4, 5, "R4 div4");
    div_window(1, 16, 3, "R4 div16");
    div_window(2, 64, 2, "R4 div64");
    div_window(3, 256, 1, "R4 div256");
    div_window(4, 1024, 1, "R4 div1024");

    // R5 reserved code and rtc source
    div_window(5, 50, 0, "R5 reserved no count");
    wr(a_cnt(0), 32'd100);
    wr(a_ctrl(0), 32'd6);
    wr(A_START, 32'd1);
    rtc_pulse(); rtc_pulse(); rtc_pulse();
    wr(A_START, 32'd0);
    chk(a_cnt(0), 32'd97, "R5 rtc rising edges");

    // R2 / R3 start gating per channel, channel 1 addresses
    wr(a_ctrl(0), 32'h7);
    wr(a_ctrl(1), 32'h7);
    wr(a_cnt(0), 32'd50);
    wr(a_cnt(1), 32'd50);
    wr(A_START, 32'd1);
    chk(A_START, 32'd1, "R2 start readback");
    ext_pulse(); ext_pulse();
    chk(a_cnt(0), 32'd48, "R2 running channel");
    chk(a_cnt(1), 32'd50, "R2 stopped channel holds");
    chk(a_ctrl(1), 32'h7, "R3 ch1 ctrl offset");

    // R6 edge selection on channel 0 (still running)
    wr(a_ctrl(0), 32'h0F);           // falling
    @(negedge clk); ext_clk_i = 1'b1; wait_cyc(6);
    chk(a_cnt(0), 32'd48, "R6 falling ignores rise");
    ext_clk_i = 1'b0; wait_cyc(6);
    chk(a_cnt(0), 32'd47, "R6 falling counts fall");
    wr(a_ctrl(0), 32'h1F);           // both
    ext_pulse();
    chk(a_cnt(0), 32'd45, "R6 both edges");
    wr(a_ctrl(0), 32'h17);           // 10 acts as both
    ext_pulse();
    chk(a_cnt(0), 32'd43, "R6 code 10 both edges");
    wr(a_ctrl(0), 32'h07);           // rising
    @(negedge clk); ext_clk_i = 1'b1; wait_cyc(6);
    chk(a_cnt(0), 32'd42, "R6 rising counts rise");
    ext_clk_i = 1'b0; wait_cyc(6);
    chk(a_cnt(0), 32'd42, "R6 rising ignores fall");

    // R7 underflow reload, R9 irq
    wr(a_ctrl(0), 32'h27);
    wr(a_const(0), 32'd5);
    wr(a_cnt(0), 32'd1);
    ext_pulse();
    chk(a_cnt(0), 32'd0, "R7 reaches zero");
    chk(a_ctrl(0), 32'h27, "R7 no flag at zero");
    ext_pulse();
    chk(a_cnt(0), 32'd5, "R7 reload from constant");
    chk(a_ctrl(0), 32'h127, "R7 underflow flag");
    chk_irq(3'b001, "R9 underflow irq");

    // R8 flag write semantics
    wr(a_ctrl(0), 32'h127);
    chk(a_ctrl(0), 32'h127, "R8 write 1 keeps flag");
    wr(a_ctrl(0), 32'h027);
    chk(a_ctrl(0), 32'h027, "R8 write 0 clears flag");
    chk_irq(3'b000, "R9 irq drops with flag");
    wr(a_ctrl(0), 32'h07);
    wr(a_cnt(0), 32'd0);
    ext_pulse();
    chk(a_ctrl(0), 32'h107, "R7 flag without enable");
    chk_irq(3'b000, "R9 no irq while disabled");
    wr(a_ctrl(0), 32'h127);
    chk_irq(3'b001, "R9 late enable raises irq");
    wr(a_ctrl(0), 32'h0C7);
    chk(a_ctrl(0), 32'h007, "R10 ch0 has no capture bits");
    wr(A_START, 32'd0);

    // R10 capture on channel 2
    wr(a_ctrl(2), 32'h80);
    wr(a_cnt(2), 32'h1234);
    ext_pulse();
    chk(A_CAP, 32'h1234, "R10 capture value");
    chk(a_ctrl(2), 32'h280, "R10 capture flag");
    chk_irq(3'b000, "R9 mode 10 no irq");
    wr(a_ctrl(2), 32'h2C0);
    chk_irq(3'b100, "R9 mode 11 irq");
    wr(A_CAP, 32'h0);
    chk(A_CAP, 32'h1234, "R3 capture register read-only");
    wr(a_ctrl(2), 32'h000);
    wr(a_cnt(2), 32'h55);
    ext_pulse();
    chk(A_CAP, 32'h1234, "R10 mode 00 no capture");
    chk(a_ctrl(2), 32'h000, "R10 mode 00 no flag");
    wr(a_ctrl(2), 32'h88);
    wr(a_cnt(2), 32'h77);
    @(negedge clk); ext_clk_i = 1'b1; wait_cyc(6);
    chk(A_CAP, 32'h1234, "R10 falling capture ignores rise");
    ext_clk_i = 1'b0; wait_cyc(6);
    chk(A_CAP, 32'h77, "R10 falling capture");

    wait_cyc(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule